// File: doc/BRIEF.md
# NAND Sector Hamming Checker and Single-Bit Repair

This block protects one 512-byte NAND sector with a 24-bit Hamming code. A streaming generator takes the sector one byte per cycle and builds the code while the data goes by. After a read, the code found in the spare area and the code just computed are presented together on the check port. One cycle later the block reports what the difference between the two codes means. The four outcomes are: a clean sector, one flipped data bit (with its byte offset and bit index), a damaged stored code over good data, or damage it cannot repair.

The raw parity is twelve pairs. For each of the twelve bits of the bit address {byte offset, bit index}, there is one parity over all data bits whose address bit is 0 (the "even" member) and one over those whose address bit is 1 (the "odd" member). The pairs are packed into three code bytes and stored inverted. An all-zero accumulator therefore yields an all-ones code, which is also the code of an erased (all-0xFF) sector. The block flags a stored code of all ones as an erased page, separately from the class. A read-modify port repairs any byte the caller presents when that byte sits at the reported error offset.

Top module: `nand_hamming_corrector`

## Requirements
- R1: While `gen_clear` is high the generator empties its accumulators and its byte counter, so `gen_code` reads 24'hFFFFFF on the following cycle; a byte offered with `gen_valid` in the same cycle as `gen_clear` is discarded.
- R2: Each byte taken with `gen_valid` gets the next byte offset (0 to 511, wrapping). Each set bit j of byte a toggles, for every k in 0..11, the odd parity k if bit k of the address {a, j} is 1 and the even parity k otherwise.
- R3: With parity pair k = 0..11 standing for address weight 2^k, `gen_code` is the bitwise inverse of a 24-bit word whose bits 7:0 are {odd6, even6, odd5, even5, odd4, even4, odd3, even3}, bits 15:8 are {odd10, even10, odd9, even9, odd8, even8, odd7, even7}, and bits 23:16 are {odd2, even2, odd1, even1, odd0, even0, odd11, even11}, each listed from the most significant bit down.
- R4: `done` is high in exactly the cycle after a cycle with `chk_valid` high; results are registered with it and held until the next check.
- R5: When `stored_code` equals `calc_code`, `ecc_class` is 0 (clean) and `status` is 2'b00.
- R6: When the syndrome `stored_code ^ calc_code`, unpacked with the R3 layout, has exactly one bit set in every one of the twelve even/odd pairs, `ecc_class` is 1 (data bit error) and `status` is 2'b01.
- R7: For class 1, `err_bit` is {odd2, odd1, odd0} of the syndrome and `err_offset` is {odd11, ..., odd3}, the odd syndrome bits from weight 2048 down to weight 8.
- R8: When exactly one syndrome bit is set, `ecc_class` is 2 (stored code damaged, data good) and `status` is 2'b00.
- R9: Every other nonzero syndrome gives `ecc_class` 3 (uncorrectable) and `status` 2'b11 (minus one).
- R10: `erased` is high with the result exactly when the stored code was 24'hFFFFFF, independently of the class.
- R11: `fix_byte_out` equals `fix_byte_in` with bit `err_bit` inverted when the held class is 1 and `fix_offset` equals `err_offset`; in every other case it equals `fix_byte_in`.
- R12: After reset `done`, `ecc_class`, `status`, `err_offset`, `err_bit` and `erased` are all 0.
- R13: For classes 0, 2 and 3, `err_offset` and `err_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_clear | input | 1 | Restart code generation for a new sector |
| gen_valid | input | 1 | `gen_byte` carries the next sector byte |
| gen_byte | input | 8 | Sector data byte |
| gen_code | output | 24 | Inverted packed code of the bytes taken so far |
| chk_valid | input | 1 | Start a check of the two codes |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code computed over the data as read |
| done | output | 1 | Result valid, one cycle after `chk_valid` |
| ecc_class | output | 2 | 0 clean, 1 data bit, 2 code damaged, 3 uncorrectable |
| status | output | 2 | 00 no data error, 01 corrected, 11 uncorrectable |
| err_offset | output | 9 | Byte offset of the flipped data bit |
| err_bit | output | 3 | Bit index of the flipped data bit |
| erased | output | 1 | Stored code was all ones |
| fix_offset | input | 9 | Offset of the byte on the repair port |
| fix_byte_in | input | 8 | Byte to repair |
| fix_byte_out | output | 8 | Repaired byte |

## Verification
Sectors of patterned data are streamed through the generator and compared against an independent model of the parity definition. Two hand-worked single-bit sectors pin the packing and the byte counter: bit 0 of byte 0 and bit 7 of byte 511 give complementary codes. Each sector is then checked clean, with one data bit flipped at the first and last offset and bit positions, with one stored-code bit flipped at either end of the word, and with two data bits flipped, both in one byte and in distant bytes. These cases separate the one-bit-per-pair data pattern from the single-bit code pattern and from the paired, even-weight patterns that two errors produce. An erased sector is checked clean and again with one zero bit, which shows that the erased flag does not depend on the class. The repair port is probed at the reported offset and one byte away from it.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int SECTOR_BYTES = 512;
    localparam int DATA_W       = 8;
    localparam int OFF_W        = $clog2(SECTOR_BYTES);
    localparam int BIT_W        = $clog2(DATA_W);
    localparam int ADDR_W       = OFF_W + BIT_W;
    localparam int CODE_W       = 2 * ADDR_W;

    typedef enum logic [1:0] {
        CLS_CLEAN = 2'd0,
        CLS_DATA  = 2'd1,
        CLS_CODE  = 2'd2,
        CLS_FAIL  = 2'd3
    } ecc_class_e;

    // one parity per address bit for each polarity of that bit
    typedef struct packed {
        logic [ADDR_W-1:0] odd;
        logic [ADDR_W-1:0] even;
    } par_pair_t;

    typedef struct packed {
        ecc_class_e       cls;
        logic [OFF_W-1:0] off;
        logic [BIT_W-1:0] bitn;
        logic             erased;
    } ecc_verdict_t;

    // interleaved packing of the twelve pairs into three code bytes
    function automatic logic [CODE_W-1:0] pack_code(par_pair_t p);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int j = 0; j < 4; j++) begin
            c[2*j]     = p.even[3+j];
            c[2*j+1]   = p.odd[3+j];
            c[8+2*j]   = p.even[7+j];
            c[9+2*j]   = p.odd[7+j];
        end
        c[16] = p.even[ADDR_W-1];
        c[17] = p.odd[ADDR_W-1];
        for (int j = 0; j < 3; j++) begin
            c[18+2*j] = p.even[j];
            c[19+2*j] = p.odd[j];
        end
        return c;
    endfunction

    function automatic par_pair_t unpack_code(logic [CODE_W-1:0] c);
        par_pair_t p;
        for (int j = 0; j < 4; j++) begin
            p.even[3+j] = c[2*j];
            p.odd[3+j]  = c[2*j+1];
            p.even[7+j] = c[8+2*j];
            p.odd[7+j]  = c[9+2*j];
        end
        p.even[ADDR_W-1] = c[16];
        p.odd[ADDR_W-1]  = c[17];
        for (int j = 0; j < 3; j++) begin
            p.even[j] = c[18+2*j];
            p.odd[j]  = c[19+2*j];
        end
        return p;
    endfunction

    function automatic logic [1:0] status_of(ecc_class_e cls);
        case (cls)
            CLS_DATA: return 2'b01;
            CLS_FAIL: return 2'b11;
            default:  return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/nand_ecc_parity_gen.sv
module nand_ecc_parity_gen
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);

    logic [OFF_W-1:0] cnt_q;
    par_pair_t        acc_q;
    par_pair_t        acc_d;

    // each set data bit toggles odd[k] where its address bit k is 1, even[k] otherwise
    always_comb begin
        acc_d = acc_q;
        for (int j = 0; j < DATA_W; j++) begin
            if (data[j]) begin
                acc_d.odd  = acc_d.odd  ^ {cnt_q, BIT_W'(j)};
                acc_d.even = acc_d.even ^ ~{cnt_q, BIT_W'(j)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (valid) begin
            cnt_q <= cnt_q + 1'b1;
            acc_q <= acc_d;
        end
    end

    assign code = ~pack_code(acc_q);

endmodule

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify
    import nand_ecc_pkg::*;
(
    input  logic [CODE_W-1:0] stored,
    input  logic [CODE_W-1:0] calc,
    output ecc_verdict_t      verdict
);

    par_pair_t syn;
    int        nset;

    always_comb begin
        syn            = unpack_code(stored ^ calc);
        nset           = $countones(stored ^ calc);
        verdict.erased = (stored == '1);
        verdict.off    = '0;
        verdict.bitn   = '0;
        if (nset == 0) begin
            verdict.cls = CLS_CLEAN;
        end else if (nset == 1) begin
            verdict.cls = CLS_CODE;
        end else if (&(syn.even ^ syn.odd)) begin
            verdict.cls  = CLS_DATA;
            verdict.off  = syn.odd[ADDR_W-1:BIT_W];
            verdict.bitn = syn.odd[BIT_W-1:0];
        end else begin
            verdict.cls = CLS_FAIL;
        end
    end

endmodule

// File: rtl/nand_ecc_byte_fix.sv
module nand_ecc_byte_fix
    import nand_ecc_pkg::*;
(
    input  ecc_class_e        cls,
    input  logic [OFF_W-1:0]  err_off,
    input  logic [BIT_W-1:0]  err_bit,
    input  logic [OFF_W-1:0]  fix_off,
    input  logic [DATA_W-1:0] byte_in,
    output logic [DATA_W-1:0] byte_out
);

    logic              hit;
    logic [DATA_W-1:0] mask;

    assign hit      = (cls == CLS_DATA) && (fix_off == err_off);
    assign mask     = hit ? (DATA_W'(1) << err_bit) : '0;
    assign byte_out = byte_in ^ mask;

endmodule

// File: rtl/nand_hamming_corrector.sv
module nand_hamming_corrector
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_clear,
    input  logic              gen_valid,
    input  logic [DATA_W-1:0] gen_byte,
    output logic [CODE_W-1:0] gen_code,
    input  logic              chk_valid,
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    output logic              done,
    output logic [1:0]        ecc_class,
    output logic [1:0]        status,
    output logic [OFF_W-1:0]  err_offset,
    output logic [BIT_W-1:0]  err_bit,
    output logic              erased,
    input  logic [OFF_W-1:0]  fix_offset,
    input  logic [DATA_W-1:0] fix_byte_in,
    output logic [DATA_W-1:0] fix_byte_out
);

    ecc_verdict_t verdict_d;
    ecc_verdict_t verdict_q;
    logic         done_q;

    nand_ecc_parity_gen gen_i (
        .clk   (clk),
        .rst   (rst),
        .clear (gen_clear),
        .valid (gen_valid),
        .data  (gen_byte),
        .code  (gen_code)
    );

    nand_ecc_classify cls_i (
        .stored  (stored_code),
        .calc    (calc_code),
        .verdict (verdict_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '{cls: CLS_CLEAN, off: '0, bitn: '0, erased: 1'b0};
            done_q    <= 1'b0;
        end else begin
            done_q <= chk_valid;
            if (chk_valid) begin
                verdict_q <= verdict_d;
            end
        end
    end

    nand_ecc_byte_fix fix_i (
        .cls      (verdict_q.cls),
        .err_off  (verdict_q.off),
        .err_bit  (verdict_q.bitn),
        .fix_off  (fix_offset),
        .byte_in  (fix_byte_in),
        .byte_out (fix_byte_out)
    );

    assign done       = done_q;
    assign ecc_class  = verdict_q.cls;
    assign status     = status_of(verdict_q.cls);
    assign err_offset = verdict_q.off;
    assign err_bit    = verdict_q.bitn;
    assign erased     = verdict_q.erased;

endmodule

// File: rtl/nand_hamming_corrector_chk.sv
module nand_hamming_corrector_chk
    import nand_ecc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              gen_clear,
    input logic [CODE_W-1:0] gen_code,
    input logic              chk_valid,
    input logic [CODE_W-1:0] stored_code,
    input logic [CODE_W-1:0] calc_code,
    input logic              done,
    input logic [1:0]        ecc_class,
    input logic [1:0]        status,
    input logic [OFF_W-1:0]  err_offset,
    input logic [BIT_W-1:0]  err_bit,
    input logic              erased,
    input logic [DATA_W-1:0] fix_byte_in,
    input logic [DATA_W-1:0] fix_byte_out
);

    // R1
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        gen_clear |=> (gen_code == '1));

    // R4
    done_follows_chk: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> done);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !done);

    // R5
    clean_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ecc_class == 2'd0) |-> ($past(stored_code == calc_code) && status == 2'b00));

    // R6
    data_weight_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ecc_class == 2'd1) |-> ($countones($past(stored_code ^ calc_code)) == ADDR_W));

    // R8
    code_weight_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ecc_class == 2'd2) |-> ($countones($past(stored_code ^ calc_code)) == 1));

    // R10
    erased_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (erased == ($past(stored_code) == '1)));

    // R13
    no_location_chk: assert property (@(posedge clk) disable iff (rst)
        (ecc_class != 2'd1) |-> (err_offset == '0 && err_bit == '0));

    // R11
    fix_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (ecc_class != 2'd1) |-> (fix_byte_out == fix_byte_in));

endmodule

bind nand_hamming_corrector nand_hamming_corrector_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .gen_clear   (gen_clear),
    .gen_code    (gen_code),
    .chk_valid   (chk_valid),
    .stored_code (stored_code),
    .calc_code   (calc_code),
    .done        (done),
    .ecc_class   (ecc_class),
    .status      (status),
    .err_offset  (err_offset),
    .err_bit     (err_bit),
    .erased      (erased),
    .fix_byte_in (fix_byte_in),
    .fix_byte_out(fix_byte_out)
);

// File: tb/nand_hamming_corrector_tb_top.sv
module nand_hamming_corrector_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen_clear = 1'b0;
    logic        gen_valid = 1'b0;
    logic [7:0]  gen_byte = '0;
    logic [23:0] gen_code;
    logic        chk_valid = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic        done;
    logic [1:0]  ecc_class;
    logic [1:0]  status;
    logic [8:0]  err_offset;
    logic [2:0]  err_bit;
    logic        erased;
    logic [8:0]  fix_offset = '0;
    logic [7:0]  fix_byte_in = '0;
    logic [7:0]  fix_byte_out;

    int nchk  = 0;
    int nfail = 0;
    logic [7:0] sect [512];

    always #10 clk = ~clk;

    nand_hamming_corrector dut_i (.*);

    // fields: erased fill, kind, offset a, bit a, offset b, bit b, code bit
    // kind 0 clean, 1 one data bit, 2 one stored-code bit, 3 two data bits
    typedef struct packed {
        logic       ff;
        logic [1:0] kind;
        logic [8:0] oa;
        logic [2:0] ba;
        logic [8:0] ob;
        logic [2:0] bb;
        logic [4:0] cb;
    } vec_t;

    localparam logic [31:0] VECS [10] = '{
        {1'b0, 2'd0, 9'd0,   3'd0, 9'd0,   3'd0, 5'd0},
        {1'b0, 2'd1, 9'd0,   3'd0, 9'd0,   3'd0, 5'd0},
        {1'b0, 2'd1, 9'd511, 3'd7, 9'd0,   3'd0, 5'd0},
        {1'b0, 2'd1, 9'd300, 3'd5, 9'd0,   3'd0, 5'd0},
        {1'b0, 2'd2, 9'd12,  3'd0, 9'd0,   3'd0, 5'd0},
        {1'b0, 2'd2, 9'd40,  3'd0, 9'd0,   3'd0, 5'd23},
        {1'b0, 2'd3, 9'd10,  3'd1, 9'd10,  3'd6, 5'd0},
        {1'b0, 2'd3, 9'd3,   3'd2, 9'd400, 3'd2, 5'd0},
        {1'b1, 2'd0, 9'd0,   3'd0, 9'd0,   3'd0, 5'd0},
        {1'b1, 2'd1, 9'd77,  3'd3, 9'd0,   3'd0, 5'd0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // code bit that carries pair k of the given polarity (R3)
    function automatic int code_pos(int k, bit odd);
        if (k <= 2)      return 18 + 2*k + int'(odd);
        else if (k <= 6) return 2*(k-3) + int'(odd);
        else if (k <= 10) return 8 + 2*(k-7) + int'(odd);
        else             return 16 + int'(odd);
    endfunction

    function automatic logic [23:0] ref_code();
        logic [11:0] ev = '0;
        logic [11:0] od = '0;
        logic [23:0] raw = '0;
        for (int a = 0; a < 512; a++) begin
            for (int j = 0; j < 8; j++) begin
                if (sect[a][j]) begin
                    for (int k = 0; k < 12; k++) begin
                        if (((a * 8 + j) >> k) & 1) od[k] = ~od[k];
                        else                        ev[k] = ~ev[k];
                    end
                end
            end
        end
        for (int k = 0; k < 12; k++) begin
            raw[code_pos(k, 1'b0)] = ev[k];
            raw[code_pos(k, 1'b1)] = od[k];
        end
        return ~raw;
    endfunction

    task automatic stream();
        @(negedge clk);
        gen_clear = 1'b1;
        @(negedge clk);
        gen_clear = 1'b0;
        for (int a = 0; a < 512; a++) begin
            gen_valid = 1'b1;
            gen_byte  = sect[a];
            @(negedge clk);
        end
        gen_valid = 1'b0;
    endtask

    task automatic run_check(input logic [23:0] s, input logic [23:0] c);
        @(negedge clk);
        chk_valid   = 1'b1;
        stored_code = s;
        calc_code   = c;
        @(negedge clk);
        chk_valid = 1'b0;
        check("R4", "done high after chk_valid", 32'(done), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R4 watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        vec_t        v;
        logic [23:0] good;
        logic [23:0] st;
        logic [23:0] ca;
        logic [1:0]  ecls;
        logic [1:0]  estat;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R12", "reset done", 32'(done), 32'd0);
        check("R12", "reset class", 32'(ecc_class), 32'd0);
        check("R12", "reset status", 32'(status), 32'd0);
        check("R12", "reset offset/bit", {20'd0, err_offset, err_bit}, 32'd0);
        check("R12", "reset erased", 32'(erased), 32'd0);
        check("R1", "code after reset", 32'(gen_code), 32'hFFFFFF);

        // R1: clear wins over a byte in the same cycle
        @(negedge clk);
        gen_clear = 1'b1; gen_valid = 1'b1; gen_byte = 8'h5A;
        @(negedge clk);
        gen_clear = 1'b0; gen_valid = 1'b0;
        check("R1", "clear beats valid", 32'(gen_code), 32'hFFFFFF);

        // R2/R3: bit 0 of byte 0 sets all even parities
        for (int a = 0; a < 512; a++) sect[a] = 8'h00;
        sect[0] = 8'h01;
        stream();
        check("R3", "lowest bit code", 32'(gen_code), 32'hAAAAAA);
        // R2: bit 7 of byte 511 sets all odd parities
        sect[0] = 8'h00; sect[511] = 8'h80;
        stream();
        check("R2", "highest bit code", 32'(gen_code), 32'h555555);

        for (int i = 0; i < 10; i++) begin
            v = vec_t'(VECS[i]);
            for (int a = 0; a < 512; a++)
                sect[a] = v.ff ? 8'hFF : 8'((a * 37) + (i * 11) + (a >> 3));
            good = ref_code();
            stream();
            check("R2", $sformatf("vec %0d generated code", i), 32'(gen_code), 32'(good));
            st = good;
            ca = good;
            ecls = 2'd0; estat = 2'b00;
            case (v.kind)
                2'd1: begin
                    sect[v.oa] = sect[v.oa] ^ (8'h01 << v.ba);
                    stream();
                    ca = gen_code;
                    ecls = 2'd1; estat = 2'b01;
                end
                2'd2: begin
                    st = good ^ (24'h1 << v.cb);
                    ecls = 2'd2; estat = 2'b00;
                end
                2'd3: begin
                    sect[v.oa] = sect[v.oa] ^ (8'h01 << v.ba);
                    sect[v.ob] = sect[v.ob] ^ (8'h01 << v.bb);
                    stream();
                    ca = gen_code;
                    ecls = 2'd3; estat = 2'b11;
                end
                default: ;
            endcase
            run_check(st, ca);
            case (ecls)
                2'd0: check("R5", $sformatf("vec %0d class", i), 32'(ecc_class), 32'(ecls));
                2'd1: check("R6", $sformatf("vec %0d class", i), 32'(ecc_class), 32'(ecls));
                2'd2: check("R8", $sformatf("vec %0d class", i), 32'(ecc_class), 32'(ecls));
                default: check("R9", $sformatf("vec %0d class", i), 32'(ecc_class), 32'(ecls));
            endcase
            check(ecls == 2'd3 ? "R9" : "R5", $sformatf("vec %0d status", i), 32'(status), 32'(estat));
            check("R10", $sformatf("vec %0d erased", i), 32'(erased), 32'(st == 24'hFFFFFF));
            if (ecls == 2'd1) begin
                check("R7", $sformatf("vec %0d offset", i), 32'(err_offset), 32'(v.oa));
                check("R7", $sformatf("vec %0d bit", i), 32'(err_bit), 32'(v.ba));
                fix_offset  = v.oa;
                fix_byte_in = sect[v.oa];
                #1;
                check("R11", $sformatf("vec %0d repaired byte", i), 32'(fix_byte_out),
                      32'(sect[v.oa] ^ (8'h01 << v.ba)));
                fix_offset = v.oa ^ 9'd1;
                #1;
                check("R11", $sformatf("vec %0d other offset", i), 32'(fix_byte_out), 32'(sect[v.oa]));
            end else begin
                check("R13", $sformatf("vec %0d no location", i), {20'd0, err_offset, err_bit}, 32'd0);
                fix_offset  = v.oa;
                fix_byte_in = sect[v.oa];
                #1;
                check("R11", $sformatf("vec %0d byte untouched", i), 32'(fix_byte_out), 32'(sect[v.oa]));
            end
            @(negedge clk);
            check("R4", $sformatf("vec %0d done one cycle", i), 32'(done), 32'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule